// File: doc/BRIEF.md
# Audio Link Incoming Frame Receiver

This block sits on the controller side of a time-division multiplexed audio link. It samples one serial data line against the link bit clock and the locally generated frame sync, then splits each frame into its slots. Slot 0 is a 16-bit tag word. It is followed by twelve 20-bit slots. The block returns the status address echo, the per-slot data-request flags, the register read data, the left and right capture samples, the modem line data and the GPIO/interrupt word as parallel registers.

Each of these outputs has a strobe that pulses for one bit period. A strobe pulses only when the tag word marked its slot as valid, so the logic downstream can push samples into its own buffers on the strobe. Slots 6 to 11 are parsed and then discarded.

Top module: `aclink_rx_frame`

## Requirements
- R1: While `rst_n` is low, every output is zero, and every output stays zero until the first frame is received.
- R2: The block samples `sync_in` and `sd_in` on the falling edge of `bit_clk`. A frame begins at the first falling edge that sees `sync_in` high after it was low, or high as the first sample after reset. Bits arrive MSB first. Frame bit 0 is tag bit 15, and bit 16 is the MSB of slot 1.
- R3: Serial bits sampled before the first sync rising edge are discarded. They produce no strobe and change no output.
- R4: At the falling edge that samples frame bit 15, `tag_q` loads the 16 tag bits and `tag_stb` rises.
- R5: Slot k (1 to 12) is valid when tag bit 15-k is set. The fields of a slot load, and the slot's strobe rises, only when that bit is set. Otherwise the fields keep their previous values.
- R6: From slot 1 the block extracts `echo_addr` from slot bits 18:12 and `req_flags` from slot bits 11:2. Slot bit 19 and bits 1:0 are ignored.
- R7: The 16-bit fields take the upper 16 bits of their slot, and the lower 4 bits are ignored: `rdata_q` comes from slot 2 and `modem_q` from slot 5.
- R8: The 20-bit fields take their whole slot: `pcm_l_q` from slot 3, `pcm_r_q` from slot 4 and `gpio_q` from slot 12.
- R9: Each strobe rises at the falling edge that samples the last bit of its slot, and stays high for exactly one bit-clock period. Slots 6 to 11 raise no strobe.
- R10: A new sync rising edge during a frame restarts the frame at bit 0. Once bit 255 has been sampled, further bits are ignored until the next sync rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; the block samples on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame sync, high for the 16 tag bits |
| sd_in | input | 1 | Incoming serial data |
| tag_q | output | 16 | Tag word of the current frame |
| tag_stb | output | 1 | Tag word loaded |
| echo_addr | output | 7 | Register address echoed in slot 1 |
| req_flags | output | 10 | Data-request flags from slot 1 |
| echo_stb | output | 1 | Slot 1 fields loaded |
| rdata_q | output | 16 | Register read data from slot 2 |
| rdata_stb | output | 1 | Slot 2 loaded |
| pcm_l_q | output | 20 | Left capture sample from slot 3 |
| pcm_l_stb | output | 1 | Slot 3 loaded |
| pcm_r_q | output | 20 | Right capture sample from slot 4 |
| pcm_r_stb | output | 1 | Slot 4 loaded |
| modem_q | output | 16 | Modem line data from slot 5 |
| modem_stb | output | 1 | Slot 5 loaded |
| gpio_q | output | 20 | GPIO and interrupt status from slot 12 |
| gpio_stb | output | 1 | Slot 12 loaded |

## Verification
The assertions assume that `sync_in` and `sd_in` change only on rising bit-clock edges. They also assume that a new sync rising edge always comes after at least one low sample, so that the slot-end bits never coincide with a restart. The stimulus meets these assumptions by driving both lines right after each rising edge. It holds sync high for exactly the 16 tag bits and cuts frames short only after sync has already fallen. Given these assumptions, the checks confirm two things: strobes are single-period pulses gated by the stored tag, and no output moves before the first frame.

// File: rtl/aclink_rx_frame.sv
module aclink_rx_frame #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12
) (
  input  logic        bit_clk,
  input  logic        rst_n,
  input  logic        sync_in,
  input  logic        sd_in,
  output logic [15:0] tag_q,
  output logic        tag_stb,
  output logic [6:0]  echo_addr,
  output logic [9:0]  req_flags,
  output logic        echo_stb,
  output logic [15:0] rdata_q,
  output logic        rdata_stb,
  output logic [19:0] pcm_l_q,
  output logic        pcm_l_stb,
  output logic [19:0] pcm_r_q,
  output logic        pcm_r_stb,
  output logic [15:0] modem_q,
  output logic        modem_stb,
  output logic [19:0] gpio_q,
  output logic        gpio_stb
);
  localparam int FRAME_BITS = TAG_W + NSLOT * SLOT_W;
  localparam int PW = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] LAST    = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] TAG_END = PW'(TAG_W - 1);
  localparam logic [PW-1:0] END1  = PW'(TAG_W + SLOT_W * 1 - 1);
  localparam logic [PW-1:0] END2  = PW'(TAG_W + SLOT_W * 2 - 1);
  localparam logic [PW-1:0] END3  = PW'(TAG_W + SLOT_W * 3 - 1);
  localparam logic [PW-1:0] END4  = PW'(TAG_W + SLOT_W * 4 - 1);
  localparam logic [PW-1:0] END5  = PW'(TAG_W + SLOT_W * 5 - 1);
  localparam logic [PW-1:0] END12 = PW'(TAG_W + SLOT_W * NSLOT - 1);

  logic              sync_q, locked;
  logic [PW-1:0]     pos;
  logic [SLOT_W-1:0] sh;

  wire              rise    = sync_in & ~sync_q;
  wire [PW-1:0]     cur_pos = rise ? '0 : pos + 1'b1;
  wire              cur_ok  = rise | (locked & (pos != LAST));
  wire [SLOT_W-1:0] word    = {sh[SLOT_W-2:0], sd_in};

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0; locked <= 1'b0; pos <= '0; sh <= '0;
      tag_q <= '0; echo_addr <= '0; req_flags <= '0; rdata_q <= '0;
      pcm_l_q <= '0; pcm_r_q <= '0; modem_q <= '0; gpio_q <= '0;
      tag_stb <= 1'b0; echo_stb <= 1'b0; rdata_stb <= 1'b0; pcm_l_stb <= 1'b0;
      pcm_r_stb <= 1'b0; modem_stb <= 1'b0; gpio_stb <= 1'b0;
    end else begin
      sync_q <= sync_in;
      sh     <= word;
      tag_stb <= 1'b0; echo_stb <= 1'b0; rdata_stb <= 1'b0; pcm_l_stb <= 1'b0;
      pcm_r_stb <= 1'b0; modem_stb <= 1'b0; gpio_stb <= 1'b0;
      if (rise) locked <= 1'b1;
      if (cur_ok) begin
        pos <= cur_pos;
        if (cur_pos == TAG_END) begin
          tag_q <= word[TAG_W-1:0]; tag_stb <= 1'b1;
        end
        if (cur_pos == END1 && tag_q[TAG_W-2]) begin
          echo_addr <= word[18:12]; req_flags <= word[11:2]; echo_stb <= 1'b1;
        end
        if (cur_pos == END2 && tag_q[TAG_W-3]) begin
          rdata_q <= word[SLOT_W-1 -: 16]; rdata_stb <= 1'b1;
        end
        if (cur_pos == END3 && tag_q[TAG_W-4]) begin
          pcm_l_q <= word; pcm_l_stb <= 1'b1;
        end
        if (cur_pos == END4 && tag_q[TAG_W-5]) begin
          pcm_r_q <= word; pcm_r_stb <= 1'b1;
        end
        if (cur_pos == END5 && tag_q[TAG_W-6]) begin
          modem_q <= word[SLOT_W-1 -: 16]; modem_stb <= 1'b1;
        end
        if (cur_pos == END12 && tag_q[TAG_W-1-NSLOT]) begin
          gpio_q <= word; gpio_stb <= 1'b1;
        end
      end
    end
  end

  wire [6:0] stbs = {tag_stb, echo_stb, rdata_stb, pcm_l_stb, pcm_r_stb, modem_stb, gpio_stb};

  AST_NO_STB_BEFORE_SYNC: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !locked |-> stbs == 7'd0); // R3
  AST_STB_ONE_PERIOD: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (stbs != 7'd0) |=> ((stbs & $past(stbs)) == 7'd0)); // R9
  AST_PCM_L_GATED: assert property (@(negedge bit_clk) disable iff (!rst_n)
    pcm_l_stb |-> tag_q[TAG_W-4]); // R5
  AST_GPIO_GATED: assert property (@(negedge bit_clk) disable iff (!rst_n)
    gpio_stb |-> tag_q[TAG_W-1-NSLOT]); // R5
  AST_PCM_L_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !pcm_l_stb |-> $stable(pcm_l_q)); // R5
  AST_SINGLE_STB: assert property (@(negedge bit_clk) disable iff (!rst_n)
    $countones(stbs) <= 1); // R9
endmodule

// File: tb/tb_aclink_rx_frame.sv
module tb_aclink_rx_frame;
  logic bit_clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0, sd_in = 1'b0;
  always #4 bit_clk = ~bit_clk;

  logic [15:0] tag_q, rdata_q, modem_q;
  logic [6:0]  echo_addr;
  logic [9:0]  req_flags;
  logic [19:0] pcm_l_q, pcm_r_q, gpio_q;
  logic tag_stb, echo_stb, rdata_stb, pcm_l_stb, pcm_r_stb, modem_stb, gpio_stb;

  aclink_rx_frame dut (.*);

  int nvec = 0, nbad = 0;
  logic [15:0] e_tag = '0, e_rdata = '0, e_modem = '0;
  logic [6:0]  e_addr = '0;
  logic [9:0]  e_req = '0;
  logic [19:0] e_l = '0, e_r = '0, e_gpio = '0;
  logic [19:0] slot [1:12];

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] fields();
    return {tag_q, echo_addr, req_flags, rdata_q, pcm_l_q, pcm_r_q, modem_q, gpio_q};
  endfunction
  function automatic logic [127:0] e_fields();
    return {e_tag, e_addr, e_req, e_rdata, e_l, e_r, e_modem, e_gpio};
  endfunction
  function automatic logic [6:0] stbs();
    return {tag_stb, echo_stb, rdata_stb, pcm_l_stb, pcm_r_stb, modem_stb, gpio_stb};
  endfunction

  // Sync low; every strobe and field must stay put (R3, R10)
  task automatic idle(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(posedge bit_clk); sync_in = 1'b0; sd_in = 1'((i * 7 + seed) % 3 == 0);
      @(negedge bit_clk); #2;
      chk("R3 R10 idle strobes", 128'(stbs()), 128'd0);
      chk("R3 R10 idle fields", fields(), e_fields());
    end
  endtask

  task automatic frame(logic [15:0] tag, int nbits, int seed);
    for (int k = 1; k <= 12; k++)
      slot[k] = 20'((seed * 7919 + k * 104729) ^ (seed << k) ^ (k * 3331));
    for (int i = 0; i < nbits; i++) begin
      logic [6:0] es;
      @(posedge bit_clk);
      sync_in = (i < 16);
      sd_in = (i < 16) ? tag[15 - i] : slot[(i - 16) / 20 + 1][19 - (i - 16) % 20];
      @(negedge bit_clk); #2;
      es = '0;
      if (i == 15) begin es[6] = 1'b1; e_tag = tag; end // R4
      if (i >= 35 && (i - 15) % 20 == 0) begin
        int k = (i - 15) / 20;
        if (tag[15 - k]) begin // R5
          case (k)
            1:  begin es[5] = 1'b1; e_addr = slot[1][18:12]; e_req = slot[1][11:2]; end // R6
            2:  begin es[4] = 1'b1; e_rdata = slot[2][19:4]; end // R7
            3:  begin es[3] = 1'b1; e_l = slot[3]; end // R8
            4:  begin es[2] = 1'b1; e_r = slot[4]; end
            5:  begin es[1] = 1'b1; e_modem = slot[5][19:4]; end
            12: begin es[0] = 1'b1; e_gpio = slot[12]; end
            default: ;
          endcase
        end
      end
      chk("R2 R9 strobes", 128'(stbs()), 128'(es));
      chk("R5 R6 R7 R8 fields", fields(), e_fields());
    end
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge bit_clk);
    #1 chk("R1 reset fields", fields(), 128'd0);
    chk("R1 reset strobes", 128'(stbs()), 128'd0);
    @(posedge bit_clk); rst_n = 1'b1;
    idle(50, 1);                                  // R3 data before first sync
    frame(16'hFFF8, 256, 2);
    frame(16'h0000, 256, 3);
    for (int k = 0; k <= 12; k++)
      frame(16'(16'h8000 >> k), 256, 10 + k);    // walking tag bit
    frame(16'hAAA8, 256, 30);
    frame(16'h5550, 256, 31);
    frame(16'hFFF8, 40, 40);                      // R10 cut short, restart
    frame(16'hFFF8, 256, 41);
    idle(30, 5);                                  // R10 bits past 255 ignored
    frame(16'hFFF8, 256, 42);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule